// File: doc/BRIEF.md
# Digital Input Pattern-Match Interrupt Unit

This block watches a digital input port of configurable width and raises an interrupt in one of two modes. In match mode it fires when every input bit that takes part in detection equals the matching bit of a compare word. In event mode it fires when any such bit differs from the last snapshot the block took. A per-bit ignore mask selects which bits take part in detection.

Each interrupt produces a one-clock pulse. It also sets a sticky pending flag, which software clears. On every interrupt the block copies the whole input word into a capture register. In event mode this re-arms change detection against the new snapshot. Software reaches the mode, mask, compare, capture and pending state through a small register port with synchronous writes and combinational reads. The port inputs are taken through a two-flop synchronizer before they are compared.

Top module: `pmi_irq_unit`

## Requirements
- R1: After reset the mode is disabled, mask, compare and capture read as zero, the pending flag reads 0 and `irq_pulse` is low.
- R2: Mode code 0 (disabled) and mode code 3 produce no interrupt, whatever the input does.
- R3: In mode code 1 (match), an interrupt fires when ((input XOR compare) AND NOT mask) becomes all zeros. A match that persists gives only one pulse until the match is lost and regained.
- R4: In mode code 2 (event), an interrupt fires when ((input XOR capture) AND NOT mask) has any bit set.
- R5: A mask bit of 1 removes that input bit from detection. A mask bit of 0 keeps it in.
- R6: On every interrupt the capture register takes the full synchronized input word, masked bits included. Otherwise it holds its value.
- R7: A software write to capture (address 3) takes effect only while the mode is 0 or 3. In modes 1 and 2 the write is ignored.
- R8: Address 0 holds the mode in bits [1:0]. Addresses 1, 2 and 3 hold mask, compare and capture, each full width. All of them read back what was written.
- R9: The input passes through two synchronizer flops, so `irq_pulse` goes high after the third rising clock edge following an input change.
- R10: Each interrupt gives a one-clock `irq_pulse` and sets the pending flag, which is visible on `irq_pending` and in bit 0 at address 4. Writing 1 to bit 0 at address 4 clears the flag. A new interrupt in the same cycle wins over the clear.
- R11: Any write to the mode register clears the match history. A match already present when match mode is written fires once, on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_in | input | W | Asynchronous digital input port |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 mode, 1 mask, 2 compare, 3 capture, 4 pending) |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data, combinational on `reg_addr` |
| irq_pulse | output | 1 | One-clock interrupt pulse |
| irq_pending | output | 1 | Sticky pending flag |

## Verification
In match mode the bench first enters the state with a word whose unmasked high byte differs from the compare word, then with one that agrees. It then changes only the masked low byte, which shows that a held match does not pulse again and that masked bits are ignored. It then breaks the match and restores it, which separates edge detection from level detection. In event mode it flips a masked bit, then an unmasked bit, then holds the input steady, which shows the difference between ignored changes, real changes and the re-arm through capture. Further runs land a clear and an interrupt in the same cycle, rewrite the mode while a match is present, and write capture while the block is active, which pins down the priority rules.

// File: rtl/pmi_pkg.sv
`timescale 1ns/1ps
package pmi_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_MATCH = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_RSVD  = 2'd3
  } pmi_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PEND = 3'd4;

  function automatic logic mode_is_active(input pmi_mode_e m);
    return (m == MODE_MATCH) || (m == MODE_EVENT);
  endfunction
endpackage

// File: rtl/pmi_sync.sv
`timescale 1ns/1ps
module pmi_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/pmi_regs.sv
`timescale 1ns/1ps
module pmi_regs
  import pmi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              fire,
  input  logic [W-1:0]      sync_val,
  output pmi_mode_e         mode_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      cmp_q,
  output logic [W-1:0]      cap_q,
  output logic              pend_q,
  output logic              mode_wr,
  output logic [W-1:0]      rdata
);
  logic wr_mask, wr_cmp, wr_cap, wr_clr, cap_idle;

  assign mode_wr  = wr_en && (addr == A_MODE);
  assign wr_mask  = wr_en && (addr == A_MASK);
  assign wr_cmp   = wr_en && (addr == A_CMP);
  assign wr_cap   = wr_en && (addr == A_CAP);
  assign wr_clr   = wr_en && (addr == A_PEND) && wdata[0];
  assign cap_idle = !mode_is_active(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      mask_q <= '0;
      cmp_q  <= '0;
      cap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= pmi_mode_e'(wdata[1:0]);
      if (wr_mask) mask_q <= wdata;
      if (wr_cmp)  cmp_q  <= wdata;
      if (fire)                   cap_q <= sync_val;
      else if (wr_cap && cap_idle) cap_q <= wdata;
      if (fire)        pend_q <= 1'b1;
      else if (wr_clr) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE: rdata[1:0] = mode_q;
      A_MASK: rdata = mask_q;
      A_CMP:  rdata = cmp_q;
      A_CAP:  rdata = cap_q;
      A_PEND: rdata[0] = pend_q;
      default: rdata = '0;
    endcase
  end

  assert_capture_on_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cap_q == $past(sync_val)));
  assert_capture_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cap && !cap_idle && !fire) |=> $stable(cap_q));
  assert_pending_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pend_q);
  assert_pending_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !fire) |=> !pend_q);
endmodule

// File: rtl/pmi_detect.sv
`timescale 1ns/1ps
module pmi_detect
  import pmi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pmi_mode_e    mode,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] cap,
  input  logic [W-1:0] sync_val,
  input  logic         mode_wr,
  output logic         fire,
  output logic         irq_q
);
  function automatic logic pattern_equal(input logic [W-1:0] v,
                                         input logic [W-1:0] ref_w,
                                         input logic [W-1:0] ign);
    return ((v ^ ref_w) & ~ign) == '0;
  endfunction

  function automatic logic any_change(input logic [W-1:0] v,
                                      input logic [W-1:0] snap,
                                      input logic [W-1:0] ign);
    return |((v ^ snap) & ~ign);
  endfunction

  logic match_now, change_now, match_prev_q, match_fire, event_fire;

  assign match_now  = pattern_equal(sync_val, cmp, mask);
  assign change_now = any_change(sync_val, cap, mask);
  assign match_fire = (mode == MODE_MATCH) && match_now && !match_prev_q;
  assign event_fire = (mode == MODE_EVENT) && change_now;
  assign fire       = match_fire || event_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_prev_q <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      if (mode_wr)                  match_prev_q <= 1'b0;
      else if (mode == MODE_MATCH)  match_prev_q <= match_now;
      else                          match_prev_q <= 1'b0;
      irq_q <= fire;
    end
  end

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_is_active(mode) |=> !irq_q);
  assert_match_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_fire && !mode_wr) |=> !match_fire);
endmodule

// File: rtl/pmi_irq_unit.sv
`timescale 1ns/1ps
module pmi_irq_unit
  import pmi_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      port_in,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq_pulse,
  output logic              irq_pending
);
  logic [W-1:0] sync_val, mask_q, cmp_q, cap_q;
  pmi_mode_e    mode_q;
  logic         mode_wr, fire;

  pmi_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(port_in), .d_out(sync_val)
  );

  pmi_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .fire(fire), .sync_val(sync_val),
    .mode_q(mode_q), .mask_q(mask_q), .cmp_q(cmp_q), .cap_q(cap_q),
    .pend_q(irq_pending), .mode_wr(mode_wr), .rdata(reg_rdata)
  );

  pmi_detect #(.W(W)) u_detect (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .mask(mask_q), .cmp(cmp_q),
    .cap(cap_q), .sync_val(sync_val), .mode_wr(mode_wr),
    .fire(fire), .irq_q(irq_pulse)
  );

  assert_pulse_sets_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_pending);
  assert_pulse_carries_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (cap_q == $past(sync_val)));
endmodule

// File: tb/test_pmi_irq_unit.sv
`timescale 1ns/1ps
module test_pmi_irq_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] port_in;
  logic         reg_wr_en;
  logic [2:0]   reg_addr;
  logic [W-1:0] reg_wdata;
  logic [W-1:0] reg_rdata;
  logic         irq_pulse, irq_pending;

  int total = 0, bad = 0, pulses = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  bit           finished = 0;

  always #2 clk = ~clk;

  pmi_irq_unit #(.W(W)) i_pmi_irq_unit (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse), .irq_pending(irq_pending)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 3'd3;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
    #0.5 reg_addr = 3'd3;
  endtask

  task automatic drive(input logic [W-1:0] v);
    @(negedge clk);
    port_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(input logic [W-1:0] cap, input string tag);
    exp_q.push_back(cap);
    tag_q.push_back(tag);
  endtask

  task automatic queue_empty(input string req);
    check(exp_q.size() == 0, req, "expected pulse missing", W'(exp_q.size()), '0);
  endtask

  // Scoreboard monitor: every pulse must match a queued capture value.
  always @(negedge clk) begin
    logic [W-1:0] e;
    string t;
    #1;
    if (rst_n === 1'b1 && irq_pulse === 1'b1) begin
      pulses++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected pulse, capture", reg_rdata, '0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(reg_rdata == e, t, "capture at pulse", reg_rdata, e);
        check(irq_pending == 1'b1, "R10", "pending at pulse", W'(irq_pending), 1);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    int p0;
    rst_n = 1'b0; port_in = '0; reg_wr_en = 1'b0; reg_addr = 3'd3; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    #1;
    check(irq_pulse == 1'b0, "R1", "pulse after reset", W'(irq_pulse), 0);
    check(irq_pending == 1'b0, "R1", "pending after reset", W'(irq_pending), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check(v == '0, "R1", "register after reset", v, '0);
    end

    // R2: mode 3 acts as disabled
    wr(3'd0, 16'd3);
    rd(3'd0, v);
    check(v == 16'd3, "R8", "mode readback", v, 16'd3);
    p0 = pulses;
    drive(16'h0F0F); idle(5);
    check(pulses == p0, "R2", "pulses in mode 3", W'(pulses - p0), 0);
    wr(3'd0, 16'd0);
    drive(16'h0000); idle(4);
    check(pulses == p0, "R2", "pulses in mode 0", W'(pulses - p0), 0);

    // R7/R8: capture writable while disabled, mask/compare readback
    wr(3'd3, 16'h00F0); rd(3'd3, v);
    check(v == 16'h00F0, "R7", "capture write while off", v, 16'h00F0);
    wr(3'd1, 16'h00FF); rd(3'd1, v);
    check(v == 16'h00FF, "R8", "mask readback", v, 16'h00FF);
    wr(3'd2, 16'h1200); rd(3'd2, v);
    check(v == 16'h1200, "R8", "compare readback", v, 16'h1200);

    // Match mode, no match on entry
    wr(3'd0, 16'd1); idle(3);
    check(pulses == p0, "R3", "no pulse without match", W'(pulses - p0), 0);

    // R9 latency and R3 first match
    expect_pulse(16'h1234, "R3");
    drive(16'h1234);
    @(negedge clk); #1 check(irq_pulse == 1'b0, "R9", "pulse after edge 1", W'(irq_pulse), 0);
    @(negedge clk); #1 check(irq_pulse == 1'b0, "R9", "pulse after edge 2", W'(irq_pulse), 0);
    @(negedge clk); #1 check(irq_pulse == 1'b1, "R9", "pulse after edge 3", W'(irq_pulse), 1);
    idle(2);
    queue_empty("R3");
    rd(3'd4, v);
    check(v == 16'd1, "R10", "pending set", v, 16'd1);
    wr(3'd4, 16'd1); rd(3'd4, v);
    check(v == 16'd0, "R10", "pending cleared", v, 16'd0);

    // Held match with masked bit changes: no second pulse
    p0 = pulses;
    drive(16'h12AB); idle(6);
    check(pulses == p0, "R5", "masked change in held match", W'(pulses - p0), 0);
    rd(3'd3, v);
    check(v == 16'h1234, "R6", "capture holds without interrupt", v, 16'h1234);

    // Lose and regain the match
    drive(16'h1334); idle(5);
    check(pulses == p0, "R3", "no pulse on lost match", W'(pulses - p0), 0);
    expect_pulse(16'h12FF, "R6");
    drive(16'h12FF); idle(5);
    queue_empty("R3");

    // R7: capture write ignored while active
    wr(3'd3, 16'hAAAA); rd(3'd3, v);
    check(v == 16'h12FF, "R7", "capture write in match mode", v, 16'h12FF);

    // R11: mode rewrite with a present match
    expect_pulse(16'h12FF, "R11");
    wr(3'd0, 16'd1); idle(3);
    queue_empty("R11");

    // Event mode
    p0 = pulses;
    wr(3'd0, 16'd2); idle(3);
    check(pulses == p0, "R4", "no pulse on event entry", W'(pulses - p0), 0);
    drive(16'h12FE); idle(5);
    check(pulses == p0, "R5", "masked change in event mode", W'(pulses - p0), 0);
    expect_pulse(16'h13FE, "R4");
    drive(16'h13FE); idle(6);
    queue_empty("R4");
    check(pulses == p0 + 1, "R4", "single pulse after rearm", W'(pulses - p0), 1);
    expect_pulse(16'h03FE, "R4");
    drive(16'h03FE); idle(5);
    queue_empty("R4");

    // R10 priority: interrupt and clear in the same cycle
    wr(3'd4, 16'd1); rd(3'd4, v);
    check(v == 16'd0, "R10", "pending cleared before race", v, 16'd0);
    expect_pulse(16'hFFFE, "R10");
    drive(16'hFFFE);
    @(posedge clk); @(posedge clk);
    wr(3'd4, 16'd1);
    rd(3'd4, v);
    check(v == 16'd1, "R10", "interrupt wins over clear", v, 16'd1);
    queue_empty("R10");
    wr(3'd4, 16'd1); rd(3'd4, v);
    check(v == 16'd0, "R10", "pending clear alone", v, 16'd0);

    // Back to disabled: capture writable again, mode 3 quiet
    wr(3'd0, 16'd0);
    wr(3'd3, 16'h5555); rd(3'd3, v);
    check(v == 16'h5555, "R7", "capture write after disable", v, 16'h5555);
    wr(3'd0, 16'd3);
    p0 = pulses;
    drive(16'h0000); idle(5);
    check(pulses == p0, "R2", "mode 3 ignores input", W'(pulses - p0), 0);
    queue_empty("R2");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule